// File: doc/BRIEF.md
# PS/2 Mouse Click Wake Detector

This block runs from an always-on 32.768 kHz clock and listens to the PS/2 mouse clock and data lines. It turns device-to-host frames back into bytes and groups the bytes into three-byte movement packets. It compares the button bits of each packet with the previous packet. When the chosen mouse event occurs, it sets a sticky status flag. That event is a single press of one button, or two left presses close enough together to count as a double-click. If the matching enable is set, the status flag drives a wake request.

A small register file holds the settings:

- **Double-click window.** A 6-bit value in steps of 2816 clock cycles.
- **Event selector.**
- **Control.** A sticky lock, an active-low feature switch, line isolation and the wake enable.
- **Status.** A flag that is cleared by writing 1 to it.

Isolation holds the copy of the mouse lines that goes to the keyboard controller at logic high. The detector still sees the real line levels.

Top module: `mouse_click_wake`

## Requirements
- R1: After reset the registers read as follows: window (address 0) = 12; selector (address 1) = 0; control (address 2) = 0; status (address 3) = 0. The wake output is 0.
- R2: A frame is accepted only when all of these hold: start bit 0, then eight data bits LSB first, then a parity bit giving odd parity, then stop bit 1. Data is taken on falling edges of the mouse clock. In the first byte of each packet, bits 0, 1 and 2 are the left, right and middle buttons. With selector 0, 1 or 2 (left, right, middle), a 0-to-1 change of that button from the previous packet sets status bit 0.
- R3: A frame with bad parity or a stop bit of 0 is discarded and produces no event. It also returns the packet byte position to the first byte.
- R4: With selector 3 (left double-click), a left press loads a window of window×2816 cycles. A second left press while that window is still running sets status. A press after the window has expired sets no status and opens a new window.
- R5: An accepted write to address 0 returns the detector to its initial state. The window timer stops, the byte position goes back to the first byte, and the stored button history becomes all-released.
- R6: Control bit 0 (lock) stays set once written to 1, until reset. While it is set, writes to addresses 0 and 1 have no effect.
- R7: Control bit 1 is an active-low feature switch. While it is 1, the detector is held in its initial state and no event sets status.
- R8: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. The wake output equals status bit 0 AND control bit 3 (wake enable).
- R9: While control bit 2 (isolate) is 1, the keyboard-controller copies of the mouse clock and data are 1, and the detector still decodes the real lines. While bit 2 is 0, the copies follow the inputs.
- R10: Selector codes 4 to 7 never set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz always-on clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ms_clk_i | input | 1 | Mouse clock line |
| ms_dat_i | input | 1 | Mouse data line |
| kbc_clk_o | output | 1 | Mouse clock as seen by the keyboard controller |
| kbc_dat_o | output | 1 | Mouse data as seen by the keyboard controller |
| wake_o | output | 1 | Wake request |

## Verification
The bench sends random button patterns and checks that only a real 0-to-1 change of the selected button raises status. A detector that forgets the previous packet would flag held buttons as new presses.

A corrupted first byte followed by a good packet shows whether the byte position resynchronises. A design that does not resynchronise would read buttons from a movement byte.

Double-click is tested three ways:

- a second press inside the window, which must set status;
- a second press after the window has expired, which must not;
- a window write between the two presses, which must not.

A design that does not clear its timer would report a false double-click in the last case.

The bench also checks lock, the off switch and isolation. It checks lock by reading the registers back after a write, and checks isolation by watching the keyboard-controller outputs while a click is still detected.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
  localparam logic [2:0] SEL_LEFT   = 3'd0;
  localparam logic [2:0] SEL_RIGHT  = 3'd1;
  localparam logic [2:0] SEL_MIDDLE = 3'd2;
  localparam logic [2:0] SEL_DBL    = 3'd3;

  // odd parity over data and parity bit
  function automatic logic parity_good(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction

  // window length in clock cycles
  function automatic int unsigned window_ticks(input int unsigned steps,
                                               input int unsigned per_step);
    return steps * per_step;
  endfunction
endpackage

// File: rtl/mcw_frame_rx.sv
module mcw_frame_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       line_clk,
  input  logic       line_dat,
  output logic       byte_vld,
  output logic       frame_err,
  output logic [7:0] byte_data
);
  import mcw_pkg::*;

  logic [1:0] clk_sync, dat_sync;
  logic       clk_prev;
  logic [3:0] bit_cnt;
  logic [7:0] shift_q;
  logic       par_q;
  logic       fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= 2'b11;
      dat_sync <= 2'b11;
      clk_prev <= 1'b1;
    end else begin
      clk_sync <= {clk_sync[0], line_clk};
      dat_sync <= {dat_sync[0], line_dat};
      clk_prev <= clk_sync[1];
    end
  end

  assign fall = clk_prev && !clk_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shift_q   <= '0;
      par_q     <= 1'b0;
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
      if (clr) begin
        bit_cnt <= '0;
      end else if (fall) begin
        if (bit_cnt == 4'd0) begin
          if (!dat_sync[1]) bit_cnt <= 4'd1;
        end else if (bit_cnt <= 4'd8) begin
          shift_q <= {dat_sync[1], shift_q[7:1]};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd9) begin
          par_q   <= dat_sync[1];
          bit_cnt <= 4'd10;
        end else begin
          bit_cnt <= '0;
          if (dat_sync[1] && parity_good(shift_q, par_q)) begin
            byte_vld  <= 1'b1;
            byte_data <= shift_q;
          end else begin
            frame_err <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && frame_err));
endmodule

// File: rtl/mcw_click_detect.sv
module mcw_click_detect #(
  parameter int unsigned IVL_W      = 6,
  parameter int unsigned STEP_TICKS = 2816
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_vld,
  input  logic             frame_err,
  input  logic [2:0]       btn_bits,
  input  logic [2:0]       sel,
  input  logic [IVL_W-1:0] interval,
  output logic             ev_pulse
);
  import mcw_pkg::*;

  localparam int unsigned MAX_TICKS = ((1 << IVL_W) - 1) * STEP_TICKS;
  localparam int unsigned TW        = $clog2(MAX_TICKS + 1);

  logic [1:0]    idx_q;
  logic [2:0]    btn_q;
  logic [TW-1:0] timer_q;
  logic [2:0]    rise;
  logic          dbl_hit, dbl_arm, ev_now;
  logic [TW-1:0] load_val;

  always_comb begin
    rise     = (byte_vld && idx_q == 2'd0) ? (btn_bits & ~btn_q) : 3'b000;
    dbl_hit  = (sel == SEL_DBL) && rise[0] && (timer_q != '0);
    dbl_arm  = (sel == SEL_DBL) && rise[0] && (timer_q == '0);
    load_val = TW'(window_ticks(int'(interval), STEP_TICKS));
    case (sel)
      SEL_LEFT:   ev_now = rise[0];
      SEL_RIGHT:  ev_now = rise[1];
      SEL_MIDDLE: ev_now = rise[2];
      SEL_DBL:    ev_now = dbl_hit;
      default:    ev_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      btn_q    <= '0;
      timer_q  <= '0;
      ev_pulse <= 1'b0;
    end else if (clr) begin
      idx_q    <= '0;
      btn_q    <= '0;
      timer_q  <= '0;
      ev_pulse <= 1'b0;
    end else begin
      ev_pulse <= ev_now;
      if (frame_err)     idx_q <= '0;
      else if (byte_vld) idx_q <= (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
      if (byte_vld && idx_q == 2'd0) btn_q <= btn_bits;
      if (dbl_arm)              timer_q <= load_val;
      else if (dbl_hit)         timer_q <= '0;
      else if (timer_q != '0)   timer_q <= timer_q - 1'b1;
    end
  end

  // R5
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (timer_q == '0 && idx_q == 2'd0 && btn_q == 3'b000));
  // R4
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_q <= TW'(MAX_TICKS));
  // R10
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > SEL_DBL && !clr) |=> !ev_pulse);
endmodule

// File: rtl/mcw_regs.sv
module mcw_regs #(
  parameter int unsigned IVL_W     = 6,
  parameter int unsigned IVL_RESET = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             ev_in,
  output logic [IVL_W-1:0] interval_q,
  output logic [2:0]       sel_q,
  output logic             lock_q,
  output logic             off_q,
  output logic             iso_q,
  output logic             pme_en_q,
  output logic             status_q,
  output logic             init_pulse
);
  logic wr_ivl, wr_sel, wr_ctl, wr_sts;

  assign wr_ivl     = we && addr == 2'd0 && !lock_q;
  assign wr_sel     = we && addr == 2'd1 && !lock_q;
  assign wr_ctl     = we && addr == 2'd2;
  assign wr_sts     = we && addr == 2'd3;
  assign init_pulse = wr_ivl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval_q <= IVL_W'(IVL_RESET);
      sel_q      <= 3'd0;
      lock_q     <= 1'b0;
      off_q      <= 1'b0;
      iso_q      <= 1'b0;
      pme_en_q   <= 1'b0;
      status_q   <= 1'b0;
    end else begin
      if (wr_ivl) interval_q <= wdata[IVL_W-1:0];
      if (wr_sel) sel_q <= wdata[2:0];
      if (wr_ctl) begin
        lock_q   <= lock_q | wdata[0];
        off_q    <= wdata[1];
        iso_q    <= wdata[2];
        pme_en_q <= wdata[3];
      end
      if (ev_in)                 status_q <= 1'b1;
      else if (wr_sts && wdata[0]) status_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = 8'(interval_q);
      2'd1:    rdata = {5'd0, sel_q};
      2'd2:    rdata = {4'd0, pme_en_q, iso_q, off_q, lock_q};
      default: rdata = {7'd0, status_q};
    endcase
  end

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && we && addr == 2'd0) |=> $stable(interval_q));
  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8
  status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(ev_in));
endmodule

// File: rtl/mouse_click_wake.sv
module mouse_click_wake #(
  parameter int unsigned IVL_W      = 6,
  parameter int unsigned IVL_RESET  = 12,
  parameter int unsigned STEP_TICKS = 2816
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ms_clk_i,
  input  logic       ms_dat_i,
  output logic       kbc_clk_o,
  output logic       kbc_dat_o,
  output logic       wake_o
);
  logic [IVL_W-1:0] interval;
  logic [2:0]       sel;
  logic             lock, off, iso, pme_en, status, init_pulse;
  logic             det_clr, byte_vld, frame_err, ev_pulse;
  logic [7:0]       rx_byte;

  assign det_clr   = init_pulse | off;
  assign kbc_clk_o = iso ? 1'b1 : ms_clk_i;
  assign kbc_dat_o = iso ? 1'b1 : ms_dat_i;
  assign wake_o    = status & pme_en;

  mcw_regs #(.IVL_W(IVL_W), .IVL_RESET(IVL_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ev_in(ev_pulse),
    .interval_q(interval), .sel_q(sel), .lock_q(lock), .off_q(off),
    .iso_q(iso), .pme_en_q(pme_en), .status_q(status),
    .init_pulse(init_pulse));

  mcw_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(det_clr),
    .line_clk(ms_clk_i), .line_dat(ms_dat_i),
    .byte_vld(byte_vld), .frame_err(frame_err), .byte_data(rx_byte));

  mcw_click_detect #(.IVL_W(IVL_W), .STEP_TICKS(STEP_TICKS)) u_det (
    .clk(clk), .rst_n(rst_n), .clr(det_clr),
    .byte_vld(byte_vld), .frame_err(frame_err), .btn_bits(rx_byte[2:0]),
    .sel(sel), .interval(interval), .ev_pulse(ev_pulse));

  // R9
  iso_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iso |-> (kbc_clk_o && kbc_dat_o));
  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !ev_pulse);
  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (pme_en && status));
endmodule

// File: tb/mouse_click_wake_bench.sv
module mouse_click_wake_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int STEP       = 2816;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic ms_clk_i = 1'b1, ms_dat_i = 1'b1;
  logic kbc_clk_o, kbc_dat_o, wake_o;

  int checks = 0, errors = 0;
  logic [2:0] prev_btn = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  mouse_click_wake u_mouse_click_wake (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ms_clk_i(ms_clk_i),
    .ms_dat_i(ms_dat_i), .kbc_clk_o(kbc_clk_o), .kbc_dat_o(kbc_dat_o),
    .wake_o(wake_o));

  function automatic logic exp_event(input logic [2:0] prev, input logic [2:0] now,
                                     input int sel);
    if (sel > 2) return 1'b0;
    return now[sel] && !prev[sel];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 2'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    logic [10:0] fr;
    fr = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); ms_dat_i = fr[i];
      repeat (HALF_BIT) @(negedge clk);
      ms_clk_i = 1'b0;
      repeat (HALF_BIT) @(negedge clk);
      ms_clk_i = 1'b1;
    end
    @(negedge clk); ms_dat_i = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_packet(input logic [2:0] btn);
    send_byte({5'b00001, btn}, 1'b0, 1'b0);
    send_byte(8'($urandom_range(0, 255)), 1'b0, 1'b0);
    send_byte(8'($urandom_range(0, 255)), 1'b0, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_status();
    wr(3, 1);
  endtask

  initial begin
    int v;
    logic [2:0] btn;
    int sel;
    bit e;
    void'($urandom(32'h1a2b3c));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(0, v); check("R1 window", v, 12);
    rd(1, v); check("R1 select", v, 0);
    rd(2, v); check("R1 control", v, 0);
    rd(3, v); check("R1 status", v, 0);
    check("R1 wake", int'(wake_o), 0);

    // R2 random single-button clicks
    for (int k = 0; k < 12; k++) begin
      sel = $urandom_range(0, 2);
      btn = 3'($urandom_range(0, 7));
      wr(1, sel);
      e = exp_event(prev_btn, btn, sel);
      send_packet(btn);
      prev_btn = btn;
      rd(3, v); check("R2 click", v, int'(e));
      clear_status();
    end

    // R3 bad parity first byte, then good packet realigns
    wr(1, 0);
    send_packet(3'b000); prev_btn = 3'b000;
    send_byte(8'b0000_1001, 1'b1, 1'b0);
    rd(3, v); check("R3 bad parity dropped", v, 0);
    send_byte(8'b0000_1001, 1'b0, 1'b1);
    rd(3, v); check("R3 bad stop dropped", v, 0);
    send_packet(3'b001); prev_btn = 3'b001;
    rd(3, v); check("R3 resync click", v, 1);
    clear_status();

    // R4 double-click inside window (interval 1 = 2816 cycles)
    wr(0, 1); prev_btn = 3'b000;
    wr(1, 3);
    send_packet(3'b001);
    rd(3, v); check("R4 first press only", v, 0);
    send_packet(3'b000);
    send_packet(3'b001);
    rd(3, v); check("R4 double inside window", v, 1);
    clear_status();
    // R4 second press after window expired
    send_packet(3'b000);
    send_packet(3'b001);
    send_packet(3'b000);
    repeat (STEP + 200) @(negedge clk);
    send_packet(3'b001);
    rd(3, v); check("R4 late press", v, 0);
    clear_status();
    // R4: window from late press still open, so next press pairs
    send_packet(3'b000);
    send_packet(3'b001);
    rd(3, v); check("R4 rearmed window", v, 1);
    clear_status();

    // R5 interval write between presses
    send_packet(3'b000);
    repeat (STEP + 200) @(negedge clk);
    send_packet(3'b001);
    wr(0, 1);
    send_packet(3'b001);
    rd(3, v); check("R5 init clears window", v, 0);
    clear_status();
    send_packet(3'b000);

    // R7 off switch
    wr(1, 0); prev_btn = 3'b000;
    wr(2, 2);
    send_packet(3'b001);
    rd(3, v); check("R7 off no event", v, 0);
    wr(2, 0);
    send_packet(3'b001);
    rd(3, v); check("R7 on history cleared", v, 1);

    // R8 wake gating and W1C
    check("R8 wake masked", int'(wake_o), 0);
    wr(2, 8);
    @(negedge clk); check("R8 wake on", int'(wake_o), 1);
    wr(3, 0);
    rd(3, v); check("R8 write 0 keeps", v, 1);
    wr(3, 1);
    rd(3, v); check("R8 W1C clears", v, 0);
    check("R8 wake off", int'(wake_o), 0);

    // R9 isolation
    send_packet(3'b000);
    wr(2, 4);
    @(negedge clk); ms_clk_i = 1'b0; ms_dat_i = 1'b0; #1;
    check("R9 iso clk high", int'(kbc_clk_o), 1);
    check("R9 iso dat high", int'(kbc_dat_o), 1);
    @(negedge clk); ms_clk_i = 1'b1; ms_dat_i = 1'b1;
    repeat (4) @(negedge clk);
    send_packet(3'b100); send_packet(3'b000);
    wr(1, 0);
    send_packet(3'b001);
    rd(3, v); check("R9 detector still sees", v, 1);
    clear_status();
    wr(2, 0);
    @(negedge clk); ms_dat_i = 1'b0; #1;
    check("R9 passthrough", int'(kbc_dat_o), 0);
    @(negedge clk); ms_dat_i = 1'b1;
    repeat (20) @(negedge clk);

    // R10 unused selector
    send_packet(3'b000);
    wr(1, 5);
    send_packet(3'b111);
    rd(3, v); check("R10 unused code", v, 0);

    // R6 lock
    wr(2, 1);
    wr(0, 9); rd(0, v); check("R6 window locked", v, 1);
    wr(1, 2); rd(1, v); check("R6 select locked", v, 5);
    wr(2, 0); rd(2, v); check("R6 lock sticky", v & 1, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule